// File: doc/BRIEF.md
# Spread Spectrum Modulation Controller

This block is the digital sweep generator of a spread-spectrum clock source. It produces a signed frequency offset, in parts per million, that follows a repeating linear triangle over a selectable band. A downstream fractional divider or digitally controlled oscillator adds this offset to its nominal ratio. The swept output clock then spreads its energy over a band instead of a single line, which lowers peak emissions.

Two controls shape the sweep. The width select picks a total spread of 12500 ppm or 37500 ppm. The mode select places that band either wholly below the nominal frequency (down-spread) or symmetric about it (center-spread). An active-low enable starts the sweep, and a restart pulse returns it to the start of its profile. The block also registers a 2-bit input-band code for the loop's configuration. From two enable pins it decodes a gate for each of six swept clock outputs, plus a gate for an unswept reference output that is always on.

Top module: `sscg_mod_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `offset_ppm` = 0, `out_gate` = 0, `ref_gate` = 0 and `band` = 0. The latched width is narrow, the latched mode is down, and the phase is 0.
- R2: When `spread_n` was high at the previous rising edge, `offset_ppm` is 0, whatever the width and mode inputs are.
- R3: With mode down (`center_sel` = 0), the offset at phase p is −(S·k div HALF_CYC). Here k = p for p < HALF_CYC and k = 2·HALF_CYC − p otherwise. S is 37500 when the latched `wide_sel` = 1 and 12500 when it is 0.
- R4: With mode center (`center_sel` = 1), the offset at phase p is S/2 − (S·k div HALF_CYC), with k and S as in R3. This gives +18750…−18750 when wide and +6250…−6250 when narrow.
- R5: The phase is 0 in the first cycle after the enable takes effect. It then rises by one per clock and wraps from 2·HALF_CYC−1 back to 0, so the sweep repeats every 2·HALF_CYC cycles. It starts at the highest-frequency end.
- R6: `wide_sel` and `center_sel` are latched only when the phase returns to 0: at a wrap, at a restart, or while the sweep is disabled. A change during a period leaves the rest of that period unchanged.
- R7: A rising edge on `restart` passes through a two-flop synchronizer and an edge detector. If `restart` rises before clock edge A, the phase is 0 after edge A+2. Holding `restart` high causes no further restart.
- R8: `out_gate` bits 0 to 4 follow `oe_lo` and bit 5 follows `oe_hi`, each one cycle later. The four input combinations give outputs none, only 5, 0 to 4, or all six.
- R9: `ref_gate` is 1 in every cycle after the first edge out of reset, whatever `spread_n` is.
- R10: `band` equals `fsel` as sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_n | input | 1 | Sweep enable, active low |
| wide_sel | input | 1 | 1: 37500 ppm total spread, 0: 12500 ppm (tie high by default) |
| center_sel | input | 1 | 1: center-spread, 0: down-spread |
| restart | input | 1 | Asynchronous restart request, rising edge active |
| fsel | input | 2 | Input band code |
| oe_lo | input | 1 | Enables swept outputs 0 to 4 |
| oe_hi | input | 1 | Enables swept output 5 |
| offset_ppm | output | OFS_W | Signed frequency offset in ppm |
| band | output | 2 | Registered band code |
| out_gate | output | N_OUT | Per-output gate for the swept outputs |
| ref_gate | output | 1 | Gate for the unswept reference output |

## Verification
Each result has a fixed delay after its stimulus:
- **Enable:** a change on `spread_n` shows on `offset_ppm` one edge later, and the first enabled cycle carries phase 0.
- **Band and gates:** `band` and `out_gate` follow their inputs one edge later.
- **Restart:** a restart lands two edges after the first sampling edge, on the third edge.
- **Width and mode:** a change first appears in the cycle after the next wrap or restart.

The bench drives inputs on falling edges and samples on the next falling edge, so every sample sits a whole number of registers after its stimulus. It steps an expected phase by the same count as the design and computes each expected offset arithmetically from the triangle formula. It compares every cycle across full periods in all four width and mode combinations, including the wrap sample.

// File: rtl/sscg_mod_ctrl.sv
module sscg_mod_ctrl #(
  parameter int HALF_CYC   = 500,
  parameter int OFS_W      = 17,
  parameter int NARROW_PPM = 12500,
  parameter int WIDE_PPM   = 37500,
  parameter int N_OUT      = 6,
  parameter int N_LOW      = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spread_n,
  input  logic                    wide_sel,
  input  logic                    center_sel,
  input  logic                    restart,
  input  logic [1:0]              fsel,
  input  logic                    oe_lo,
  input  logic                    oe_hi,
  output logic signed [OFS_W-1:0] offset_ppm,
  output logic [1:0]              band,
  output logic [N_OUT-1:0]        out_gate,
  output logic                    ref_gate
);

  localparam int PER = 2 * HALF_CYC;
  localparam int CW  = $clog2(PER + 1);
  localparam int PW  = OFS_W + CW;
  localparam logic [CW-1:0] PER_W  = CW'(PER);
  localparam logic [CW-1:0] HALF_W = CW'(HALF_CYC);
  localparam logic [CW-1:0] LAST_W = CW'(PER - 1);

  logic [CW-1:0]    ph;
  logic             cfg_w, cfg_c, en_q;
  logic [2:0]       rs;
  logic             rs_edge;
  logic [CW-1:0]    k;
  logic [OFS_W-1:0] span, top, dlt;
  logic [N_OUT-1:0] gate_c;

  assign rs_edge = rs[1] & ~rs[2];
  assign k       = (ph < HALF_W) ? ph : PER_W - ph;
  assign span    = cfg_w ? OFS_W'(WIDE_PPM) : OFS_W'(NARROW_PPM);
  assign top     = cfg_c ? (span >> 1) : '0;
  assign dlt     = OFS_W'((PW'(span) * PW'(k)) / PW'(HALF_CYC));
  assign offset_ppm = en_q ? ($signed(top) - $signed(dlt)) : '0;

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    if (g < N_LOW) begin : g_lo
      assign gate_c[g] = oe_lo;
    end else begin : g_hi
      assign gate_c[g] = oe_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      cfg_w    <= 1'b0;
      cfg_c    <= 1'b0;
      en_q     <= 1'b0;
      rs       <= '0;
      band     <= '0;
      out_gate <= '0;
      ref_gate <= 1'b0;
    end else begin
      rs       <= {rs[1:0], restart};
      en_q     <= ~spread_n;
      band     <= fsel;
      out_gate <= gate_c;
      ref_gate <= 1'b1;
      if (!en_q || rs_edge || ph == LAST_W) begin
        ph    <= '0;
        cfg_w <= wide_sel;
        cfg_c <= center_sel;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sscg_mod_ctrl_chk.sv
module sscg_mod_ctrl_chk #(
  parameter int OFS_W    = 17,
  parameter int WIDE_PPM = 37500,
  parameter int N_OUT    = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    spread_n,
  input logic                    oe_lo,
  input logic                    oe_hi,
  input logic [1:0]              fsel,
  input logic signed [OFS_W-1:0] offset_ppm,
  input logic [1:0]              band,
  input logic [N_OUT-1:0]        out_gate,
  input logic                    ref_gate
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (out_gate == '0 && !ref_gate && band == 2'd0 && offset_ppm == '0));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(spread_n) |-> offset_ppm == '0);

  // R3 R4
  band_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(offset_ppm) <= WIDE_PPM / 2) && (int'(offset_ppm) >= -WIDE_PPM));

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_lo && !oe_hi) |=> out_gate == '0);

  // R8
  gate_all_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_lo && oe_hi) |=> &out_gate);

  // R9
  ref_on_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ref_gate);

  // R10
  band_reg_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> band == $past(fsel));

endmodule

bind sscg_mod_ctrl sscg_mod_ctrl_chk #(
  .OFS_W(OFS_W), .WIDE_PPM(WIDE_PPM), .N_OUT(N_OUT)
) u_chk (
  .clk(clk), .rst(rst), .spread_n(spread_n), .oe_lo(oe_lo), .oe_hi(oe_hi),
  .fsel(fsel), .offset_ppm(offset_ppm), .band(band), .out_gate(out_gate),
  .ref_gate(ref_gate)
);

// File: tb/sim_sscg_mod_ctrl.sv
module sim_sscg_mod_ctrl;
  localparam int CLK_P = 10;
  localparam int HALF  = 500;
  localparam int PER   = 2 * HALF;

  logic clk = 1'b0, rst = 1'b1, spread_n = 1'b1, wide_sel = 1'b1, center_sel = 1'b0;
  logic restart = 1'b0, oe_lo = 1'b0, oe_hi = 1'b0;
  logic [1:0] fsel = 2'd0;
  wire signed [16:0] offset_ppm;
  wire [1:0] band;
  wire [5:0] out_gate;
  wire ref_gate;

  int checks = 0, errors = 0;

  sscg_mod_ctrl u0 (
    .clk(clk), .rst(rst), .spread_n(spread_n), .wide_sel(wide_sel),
    .center_sel(center_sel), .restart(restart), .fsel(fsel), .oe_lo(oe_lo),
    .oe_hi(oe_hi), .offset_ppm(offset_ppm), .band(band), .out_gate(out_gate),
    .ref_gate(ref_gate)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expv(input int ph, input bit w, input bit c);
    int s = w ? 37500 : 12500;
    int k = (ph < HALF) ? ph : PER - ph;
    int top = c ? s / 2 : 0;
    return top - (s * k) / HALF;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fsel = 2'd3; oe_lo = 1'b1; oe_hi = 1'b1;
    step(); step();
    chk("R1 offset", int'(offset_ppm), 0);
    chk("R1 gates", int'(out_gate), 0);
    chk("R1 ref", int'(ref_gate), 0);
    chk("R1 band", int'(band), 0);
    rst = 1'b0; oe_lo = 1'b0; oe_hi = 1'b0;
    step();
    chk("R9 ref on", int'(ref_gate), 1);
    chk("R2 idle", int'(offset_ppm), 0);

    for (int f = 0; f < 4; f++) begin
      fsel = 2'(f);
      step();
      chk("R10 band", int'(band), f);
    end

    for (int e = 0; e < 4; e++) begin
      oe_lo = e[0]; oe_hi = e[1];
      step();
      chk("R8 gates", int'(out_gate), (e[0] ? 31 : 0) + (e[1] ? 32 : 0));
      chk("R9 ref", int'(ref_gate), 1);
    end

    for (int i = 0; i < 8; i++) begin
      wide_sel = i[0]; center_sel = i[1];
      step();
      chk("R2 idle", int'(offset_ppm), 0);
    end

    for (int cfg = 0; cfg < 4; cfg++) begin
      wide_sel = cfg[0]; center_sel = cfg[1]; spread_n = 1'b1;
      step();
      spread_n = 1'b0;
      step();
      for (int i = 0; i <= PER; i++) begin
        chk(i == PER ? "R5 wrap" : (cfg[1] ? "R4 center" : "R3 down"),
            int'(offset_ppm), expv(i % PER, cfg[0], cfg[1]));
        if (i < PER) step();
      end
      spread_n = 1'b1;
      step();
      chk("R2 disable", int'(offset_ppm), 0);
      chk("R9 ref", int'(ref_gate), 1);
    end

    wide_sel = 1'b0; center_sel = 1'b0;
    step();
    spread_n = 1'b0;
    step();
    for (int i = 0; i <= PER; i++) begin
      chk("R6 latch", int'(offset_ppm), expv(i % PER, i == PER, i == PER));
      if (i == 100) begin wide_sel = 1'b1; center_sel = 1'b1; end
      if (i < PER) step();
    end

    for (int i = 1; i <= 300; i++) begin
      step();
      chk("R6 new cfg", int'(offset_ppm), expv(i, 1'b1, 1'b1));
    end
    restart = 1'b1; wide_sel = 1'b0;
    step(); chk("R7 sync1", int'(offset_ppm), expv(301, 1'b1, 1'b1));
    step(); chk("R7 sync2", int'(offset_ppm), expv(302, 1'b1, 1'b1));
    step(); chk("R7 restart", int'(offset_ppm), expv(0, 1'b0, 1'b1));
    for (int j = 1; j <= 10; j++) begin
      step();
      chk("R7 held", int'(offset_ppm), expv(j, 1'b0, 1'b1));
    end
    restart = 1'b0;

    spread_n = 1'b1;
    step();
    chk("R2 mid stop", int'(offset_ppm), 0);

    spread_n = 1'b0; oe_lo = 1'b1; fsel = 2'd2;
    step(); step();
    rst = 1'b1;
    step();
    chk("R1 offset", int'(offset_ppm), 0);
    chk("R1 gates", int'(out_gate), 0);
    chk("R1 ref", int'(ref_gate), 0);
    chk("R1 band", int'(band), 0);
    rst = 1'b0;
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule